// File: doc/BRIEF.md
# Signed-Digit Residue to Binary Converter

This block turns a number held as three residues back into ordinary binary. The residues belong to the modulus set {2^N−1, 2^N, 2^N+1}, and each one arrives as an N-digit radix-2 signed-digit word. The output is the unique unsigned 3N-bit value X in [0, M), where M = (2^N−1)·2^N·(2^N+1). The block is purely combinational. It sits after residue-domain arithmetic that keeps its residues in signed digits, where results may be redundant or lie in the negative range of a modulus.

The upper 2N bits come from a reconstruction carried out in signed digits, modulo 2^(2N)−1. Three 2N-digit operands are formed from the residues by wiring alone: negation, concatenation and a one-digit rotation. Two carry-free signed-digit adders with end-around transfer add these operands. The low N bits are the modulo-2^N residue on its own. Each part is converted to binary by subtracting its minus-digit vector from its plus-digit vector, and the borrow of the low conversion is charged to the upper part. A corrected copy of the upper digits is produced in parallel by adding all ones, which is the same as adding M to X. The sign of the uncorrected conversion chooses between the two copies, and a final fold removes the two edge values that one correction step cannot reach.

Top module: `sdres_to_bin`

## Requirements
- R1: Each digit uses two bits, one in a plus vector and one in a minus vector, with digit value plus − minus; plus=1,minus=0 is +1, plus=0,minus=1 is −1, both clear is 0, and both set is never applied. Bit k of each vector weighs 2^k.
- R2: `value` equals the X in [0, M) with X ≡ v1 mod 2^N−1, X ≡ v2 mod 2^N and X ≡ v3 mod 2^N+1, where v1, v2, v3 are the signed values of residues x1, x2, x3 (M = 16776960 for N = 8).
- R3: `value` is below M for every valid digit input.
- R4: `value[N-1:0]` equals v2 mod 2^N and does not depend on x1 or x3.
- R5: Different digit strings with the same signed value give the same `value`.
- R6: A residue given in the negative range (v − m, with m its modulus) gives the same `value` as its positive form v.
- R7: Zero-equivalent forms are accepted: x1 written as 2^N−1 or as −(2^N−1) counts as 0, and x3 = −1 stands for the residue 2^N.
- R8: The rotated operands equal x1 and x3 times 2^(N−1)·(2^N+1) modulo 2^(2N)−1, and each end-around adder returns a sum congruent to its operands' sum modulo 2^(2N)−1.
- R9: The correction path adds exactly 2^(2N)−1 to the upper digits, so a negative raw reconstruction (for example all residues equal to −1, giving M−1) is returned in range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x1_pos | input | N | Plus digits of the residue modulo 2^N−1 |
| x1_neg | input | N | Minus digits of the residue modulo 2^N−1 |
| x2_pos | input | N | Plus digits of the residue modulo 2^N |
| x2_neg | input | N | Minus digits of the residue modulo 2^N |
| x3_pos | input | N | Plus digits of the residue modulo 2^N+1 |
| x3_neg | input | N | Minus digits of the residue modulo 2^N+1 |
| value | output | 3N | Reconstructed unsigned binary value in [0, M) |

## Verification
Whenever the inputs change, the embedded assertions check that the output is below M and matches each input residue under its own modulus. They also check that the rotated operands carry the intended constant factor, that both end-around adders preserve congruence, and that the plus-ones stage adds exactly 2^(2N)−1. None of these checks can show that the chosen X is the one the caller encoded. The bench's scenarios show that: they return known values through plain, negative-range and randomly redundant digit strings, hit the zero-equivalent and all-minus-one corners, and hold x2 fixed to show the low bits ignore x1 and x3.

// File: rtl/sdrc_pkg.sv
`timescale 1ns/1ps
package sdrc_pkg;

    // Digit code as {minus, plus}
    typedef enum logic [1:0] {
        DIG_ZERO = 2'b00,
        DIG_PLUS = 2'b01,
        DIG_MINUS = 2'b10
    } sd_digit_e;

    // Transfer to the next position and interim digit left at this one
    typedef struct packed {
        logic t_pos;
        logic t_neg;
        logic u_pos;
        logic u_neg;
    } sd_split_t;

    // Path taken by the final fold of the upper part
    typedef enum logic [1:0] {
        FOLD_KEEP   = 2'b00,
        FOLD_WRAP   = 2'b01,
        FOLD_ADD_M  = 2'b10,
        FOLD_ADD_2M = 2'b11
    } fold_sel_e;

    // Carry-free split of one digit pair; lo_has_neg tells whether the
    // pair one position below holds a negative digit.
    function automatic sd_split_t split_pair(
        input logic xp, input logic xn,
        input logic yp, input logic yn,
        input logic lo_has_neg
    );
        sd_split_t r;
        logic [1:0] np;
        logic [1:0] nn;
        r  = '0;
        np = {1'b0, xp} + {1'b0, yp};
        nn = {1'b0, xn} + {1'b0, yn};
        if (np == 2'd2) begin
            r.t_pos = 1'b1;
        end else if (nn == 2'd2) begin
            r.t_neg = 1'b1;
        end else if (np == 2'd1 && nn == 2'd0) begin
            if (!lo_has_neg) begin
                r.t_pos = 1'b1;
                r.u_neg = 1'b1;
            end else begin
                r.u_pos = 1'b1;
            end
        end else if (nn == 2'd1 && np == 2'd0) begin
            if (!lo_has_neg) begin
                r.u_neg = 1'b1;
            end else begin
                r.t_neg = 1'b1;
                r.u_pos = 1'b1;
            end
        end
        return r;
    endfunction

    // Split of a digit when a constant +1 is added to it
    function automatic sd_split_t ones_split(input logic dp, input logic dn);
        sd_split_t r;
        r       = '0;
        r.t_pos = ~dn;
        r.u_neg = ~dp & ~dn;
        return r;
    endfunction

    // Final digit = interim + incoming transfer; never leaves {-1,0,1}
    function automatic sd_digit_e merge(
        input logic u_pos, input logic u_neg,
        input logic c_pos, input logic c_neg
    );
        logic p;
        logic n;
        p = (u_pos & ~c_neg) | (c_pos & ~u_neg);
        n = (u_neg & ~c_pos) | (c_neg & ~u_pos);
        return sd_digit_e'({n, p});
    endfunction

endpackage

// File: rtl/sdrc_eac_add.sv
`timescale 1ns/1ps
module sdrc_eac_add
    import sdrc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_pos,
    input  logic [W-1:0] a_neg,
    input  logic [W-1:0] b_pos,
    input  logic [W-1:0] b_neg,
    output logic [W-1:0] s_pos,
    output logic [W-1:0] s_neg
);

    sd_split_t [W-1:0] sp;

    // Position 0 sees position W-1 as its lower neighbour: the transfer
    // out of the top digit re-enters at the bottom (weight 2^W = 1).
    for (genvar i = 0; i < W; i++) begin : g_digit
        localparam int LO = (i == 0) ? W - 1 : i - 1;
        logic lo_neg;
        sd_digit_e d;
        assign lo_neg = a_neg[LO] | b_neg[LO];
        assign sp[i]  = split_pair(a_pos[i], a_neg[i], b_pos[i], b_neg[i], lo_neg);
        assign d      = merge(sp[i].u_pos, sp[i].u_neg, sp[LO].t_pos, sp[LO].t_neg);
        assign s_pos[i] = d[0];
        assign s_neg[i] = d[1];
    end

    if (W <= 30) begin : g_chk
        always_comb begin
            longint md;
            longint va;
            longint vb;
            longint vs;
            md = (longint'(1) <<< W) - 1;
            va = longint'(a_pos) - longint'(a_neg);
            vb = longint'(b_pos) - longint'(b_neg);
            vs = longint'(s_pos) - longint'(s_neg);
            a_r8_eac_congruent: assert ((vs - va - vb) % md == 0)
                else $error("end-around sum not congruent to operand sum");
        end
    end

endmodule

// File: rtl/sdrc_add_ones.sv
`timescale 1ns/1ps
module sdrc_add_ones
    import sdrc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] d_pos,
    input  logic [W-1:0] d_neg,
    output logic [W:0]   o_pos,
    output logic [W:0]   o_neg
);

    sd_split_t [W-1:0] sp;

    for (genvar i = 0; i < W; i++) begin : g_digit
        sd_digit_e d;
        assign sp[i] = ones_split(d_pos[i], d_neg[i]);
        if (i == 0) begin : g_first
            assign d = merge(sp[i].u_pos, sp[i].u_neg, 1'b0, 1'b0);
        end else begin : g_rest
            assign d = merge(sp[i].u_pos, sp[i].u_neg, sp[i-1].t_pos, sp[i-1].t_neg);
        end
        assign o_pos[i] = d[0];
        assign o_neg[i] = d[1];
    end

    assign o_pos[W] = sp[W-1].t_pos;
    assign o_neg[W] = sp[W-1].t_neg;

    if (W <= 30) begin : g_chk
        always_comb begin
            longint vi;
            longint vo;
            vi = longint'(d_pos) - longint'(d_neg);
            vo = longint'(o_pos) - longint'(o_neg);
            a_r9_adds_modulus: assert (vo == vi + ((longint'(1) <<< W) - 1))
                else $error("plus-ones stage did not add 2^W-1");
        end
    end

endmodule

// File: rtl/sdrc_sd2bin.sv
`timescale 1ns/1ps
module sdrc_sd2bin #(
    parameter int WD = 8
) (
    input  logic [WD-1:0] d_pos,
    input  logic [WD-1:0] d_neg,
    input  logic          borrow_in,
    output logic [WD:0]   diff
);

    // plus - minus - borrow, written as one addition with inverted minus bits
    assign diff = {1'b0, d_pos} + {1'b1, ~d_neg} + {{WD{1'b0}}, ~borrow_in};

endmodule

// File: rtl/sdrc_fold.sv
`timescale 1ns/1ps
module sdrc_fold
    import sdrc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W:0]   raw,
    input  logic [W+1:0] cor,
    output logic [W-1:0] upper
);

    fold_sel_e sel;
    logic      cor_unused;

    assign cor_unused = cor[W];

    always_comb begin
        if (!raw[W]) begin
            sel = (&raw[W-1:0]) ? FOLD_WRAP : FOLD_KEEP;
        end else begin
            sel = cor[W+1] ? FOLD_ADD_2M : FOLD_ADD_M;
        end
    end

    always_comb begin
        unique case (sel)
            FOLD_KEEP:   upper = raw[W-1:0];
            FOLD_WRAP:   upper = '0;
            FOLD_ADD_M:  upper = cor[W-1:0];
            FOLD_ADD_2M: upper = cor[W-1:0] - {{(W-1){1'b0}}, 1'b1};
            default:     upper = raw[W-1:0];
        endcase
    end

endmodule

// File: rtl/sdres_to_bin.sv
`timescale 1ns/1ps
module sdres_to_bin #(
    parameter int N = 8
) (
    input  logic [N-1:0]   x1_pos,
    input  logic [N-1:0]   x1_neg,
    input  logic [N-1:0]   x2_pos,
    input  logic [N-1:0]   x2_neg,
    input  logic [N-1:0]   x3_pos,
    input  logic [N-1:0]   x3_neg,
    output logic [3*N-1:0] value
);

    localparam int W  = 2 * N;
    localparam int XW = 3 * N;

    // Operand forming: wiring only
    logic [W-1:0] a_pos, a_neg;
    logic [W-1:0] dup1_pos, dup1_neg, dup3_pos, dup3_neg;
    logic [W-1:0] b_pos, b_neg, c_pos, c_neg;

    assign a_pos    = {x2_neg, x3_neg};
    assign a_neg    = {x2_pos, x3_pos};
    assign dup1_pos = {x1_pos, x1_pos};
    assign dup1_neg = {x1_neg, x1_neg};
    assign dup3_pos = {x3_pos, x3_pos};
    assign dup3_neg = {x3_neg, x3_neg};
    assign b_pos    = {dup1_pos[0], dup1_pos[W-1:1]};
    assign b_neg    = {dup1_neg[0], dup1_neg[W-1:1]};
    assign c_pos    = {dup3_pos[0], dup3_pos[W-1:1]};
    assign c_neg    = {dup3_neg[0], dup3_neg[W-1:1]};

    // Two cascaded end-around adders
    logic [W-1:0] s1_pos, s1_neg, u_pos, u_neg;

    sdrc_eac_add #(.W(W)) u_add_ab (
        .a_pos(a_pos), .a_neg(a_neg), .b_pos(b_pos), .b_neg(b_neg),
        .s_pos(s1_pos), .s_neg(s1_neg)
    );

    sdrc_eac_add #(.W(W)) u_add_c (
        .a_pos(s1_pos), .a_neg(s1_neg), .b_pos(c_pos), .b_neg(c_neg),
        .s_pos(u_pos), .s_neg(u_neg)
    );

    // Low part: x2 alone; its borrow is charged to the upper part
    logic [N:0] lo_diff;
    logic       lo_borrow;

    sdrc_sd2bin #(.WD(N)) u_cvt_lo (
        .d_pos(x2_pos), .d_neg(x2_neg), .borrow_in(1'b0), .diff(lo_diff)
    );
    assign lo_borrow = lo_diff[N];

    // Upper part, uncorrected and corrected, converted side by side
    logic [W:0]   up_raw;
    logic [W:0]   uc_pos, uc_neg;
    logic [W+1:0] up_cor;

    sdrc_sd2bin #(.WD(W)) u_cvt_raw (
        .d_pos(u_pos), .d_neg(u_neg), .borrow_in(lo_borrow), .diff(up_raw)
    );

    sdrc_add_ones #(.W(W)) u_ones (
        .d_pos(u_pos), .d_neg(u_neg), .o_pos(uc_pos), .o_neg(uc_neg)
    );

    sdrc_sd2bin #(.WD(W+1)) u_cvt_cor (
        .d_pos(uc_pos), .d_neg(uc_neg), .borrow_in(lo_borrow), .diff(up_cor)
    );

    logic [W-1:0] upper;

    sdrc_fold #(.W(W)) u_fold (
        .raw(up_raw), .cor(up_cor), .upper(upper)
    );

    assign value = {upper, lo_diff[N-1:0]};

    if (XW <= 60) begin : g_chk
        always_comb begin
            longint m1, m2, m3, mt, mw, kf;
            longint vx, v1, v2, v3, vb, vc;
            m1 = (longint'(1) <<< N) - 1;
            m2 = longint'(1) <<< N;
            m3 = (longint'(1) <<< N) + 1;
            mt = m1 * m2 * m3;
            mw = (longint'(1) <<< W) - 1;
            kf = (longint'(1) <<< (N - 1)) * m3;
            vx = longint'(value);
            v1 = longint'(x1_pos) - longint'(x1_neg);
            v2 = longint'(x2_pos) - longint'(x2_neg);
            v3 = longint'(x3_pos) - longint'(x3_neg);
            vb = longint'(b_pos) - longint'(b_neg);
            vc = longint'(c_pos) - longint'(c_neg);
            a_r3_below_m: assert (vx < mt)
                else $error("output not below M");
            a_r2_match_lo_mod: assert ((vx - v1) % m1 == 0)
                else $error("output disagrees with x1");
            a_r4_match_mid_mod: assert ((vx - v2) % m2 == 0)
                else $error("output disagrees with x2");
            a_r2_match_hi_mod: assert ((vx - v3) % m3 == 0)
                else $error("output disagrees with x3");
            a_r8_rot_x1: assert ((vb - kf * v1) % mw == 0)
                else $error("rotated x1 operand carries wrong factor");
            a_r8_rot_x3: assert ((vc - kf * v3) % mw == 0)
                else $error("rotated x3 operand carries wrong factor");
        end
    end

endmodule

// File: tb/tb_sdres_to_bin.sv
`timescale 1ns/1ps
module tb_sdres_to_bin;

    localparam int N    = 8;
    localparam int XW   = 3 * N;
    localparam int LIM  = (1 << N) - 1;
    localparam int MA   = (1 << N) - 1;
    localparam int MB   = 1 << N;
    localparam int MC   = (1 << N) + 1;
    localparam int MT   = MA * MB * MC;
    localparam int NVEC = 16;
    localparam int VEC_X [NVEC] = '{0, 1, 3, 255, 256, 257, 4660, 65280, 65535,
                                    65536, 999999, 8388480, 12345678, 16711680,
                                    16776704, 16776959};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0]  x1_pos = '0, x1_neg = '0;
    logic [N-1:0]  x2_pos = '0, x2_neg = '0;
    logic [N-1:0]  x3_pos = '0, x3_neg = '0;
    logic [XW-1:0] value;

    int n_vec = 0;
    int n_bad = 0;

    sdres_to_bin #(.N(N)) dut (
        .x1_pos(x1_pos), .x1_neg(x1_neg),
        .x2_pos(x2_pos), .x2_neg(x2_neg),
        .x3_pos(x3_pos), .x3_neg(x3_neg),
        .value(value)
    );

    task automatic check(input string req, input int got, input int exp, input string what);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Choose a signed representative of residue r (0 <= r < m)
    function automatic int pick_rep(input int r, input int m, input int style);
        int c [3];
        int cnt;
        cnt = 0;
        if (style == 0 || style == 2) return (r <= LIM) ? r : r - m;
        if (style == 1) return (r - m >= -LIM) ? r - m : r;
        if (r <= LIM)      begin c[cnt] = r;     cnt++; end
        if (r - m >= -LIM) begin c[cnt] = r - m; cnt++; end
        if (r + m <= LIM)  begin c[cnt] = r + m; cnt++; end
        return c[$urandom_range(cnt - 1, 0)];
    endfunction

    // Signed-digit string of value v; random choices when redundant
    task automatic encode(input int v, input bit red, output logic [N-1:0] p, output logic [N-1:0] n);
        int r, d, nx, k;
        p = '0;
        n = '0;
        if (!red) begin
            if (v >= 0) p = v[N-1:0];
            else        n = N'(-v);
        end else begin
            r = v;
            for (int i = 0; i < N; i++) begin
                k = N - 1 - i;
                if (r % 2 != 0) begin
                    d  = ($urandom_range(1, 0) == 1) ? 1 : -1;
                    nx = (r - d) / 2;
                    if (nx > (1 << k) - 1 || nx < -((1 << k) - 1)) begin
                        d  = -d;
                        nx = (r - d) / 2;
                    end
                    if (d > 0) p[i] = 1'b1;
                    else       n[i] = 1'b1;
                    r = nx;
                end else begin
                    r = r / 2;
                end
            end
        end
    endtask

    task automatic drive_raw(input int v1, input int v2, input int v3, input bit red);
        logic [N-1:0] p, n;
        @(posedge clk);
        encode(v1, red, p, n); x1_pos = p; x1_neg = n;
        encode(v2, red, p, n); x2_pos = p; x2_neg = n;
        encode(v3, red, p, n); x3_pos = p; x3_neg = n;
        @(negedge clk);
    endtask

    task automatic drive_x(input int x, input int style);
        drive_raw(pick_rep(x % MA, MA, style), pick_rep(x % MB, MB, style),
                  pick_rep(x % MC, MC, style), style >= 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // Idle state: all digits zero
        @(negedge clk);
        check("R2", int'(value), 0, "all-zero inputs");

        // Table walk: plain, negative-range, redundant, mixed forms
        for (int i = 0; i < NVEC; i++) begin
            for (int s = 0; s < 4; s++) begin
                drive_x(VEC_X[i], s);
                if (s == 0)      check("R2 R8", int'(value), VEC_X[i], "plain table entry");
                else if (s == 1) check("R6", int'(value), VEC_X[i], "negative-range table entry");
                else             check("R5", int'(value), VEC_X[i], "redundant table entry");
            end
        end

        // R1: single-digit weights, plus and minus
        for (int k = 0; k < N; k++) begin
            drive_raw((1 << k) % MA, 1 << k, (1 << k) % MC, 1'b0);
            check("R1", int'(value), 1 << k, "single plus digit");
            drive_raw(-((1 << k) % MA), -(1 << k), -((1 << k) % MC), 1'b0);
            check("R1", int'(value), MT - (1 << k), "single minus digit");
        end

        // R7: zero-equivalent forms
        drive_raw(LIM, 0, 0, 1'b0);
        check("R7", int'(value), 0, "x1 all plus ones");
        drive_raw(-LIM, 0, 0, 1'b0);
        check("R7", int'(value), 0, "x1 all minus ones");
        drive_raw(1, 0, -1, 1'b0);
        check("R7", int'(value), 256, "x3 minus one stands for 2^N");

        // R9: negative raw reconstructions
        drive_raw(-1, -1, -1, 1'b0);
        check("R9", int'(value), MT - 1, "all residues minus one");
        drive_raw(-1, -1, -1, 1'b1);
        check("R9", int'(value), MT - 1, "all residues minus one redundant");
        drive_raw(-2, -2, -2, 1'b0);
        check("R9", int'(value), MT - 2, "all residues minus two");

        // R4: low bits follow x2 only
        for (int j = 0; j < 12; j++) begin
            drive_raw($urandom_range(2 * LIM, 0) - LIM, -3,
                      $urandom_range(2 * LIM, 0) - LIM, 1'b1);
            check("R4", int'(value[N-1:0]), 253, "low bits with x2 = -3");
        end

        // R3 and R5: random values in random forms
        for (int j = 0; j < 300; j++) begin
            int x;
            x = int'($urandom_range(MT - 1, 0));
            drive_x(x, 3);
            check("R5", int'(value), x, "random value random form");
            check("R3", (int'(value) < MT) ? 1 : 0, 1, "output below M");
        end

        summary();
        $finish;
    end

endmodule